// File: doc/BRIEF.md
# Four-channel countdown timer with interrupts

The block holds a set of independent down-counters that share one simple register bus. The bus has an address, a write strobe, write data and combinational read data. Every channel owns a 64-byte register window that starts at the channel index times 0x40. Software writes a start value into a channel, selects whether the channel repeats or stops after one pass, and turns it on. The counter then steps down by one on each clock and raises a pending flag each time it passes through zero.

The pending flag of each channel drives an interrupt line unless the channel masks it. Software clears the flag through a per-channel clear register, which also shows a short busy window after each clear. A shared status word lists the pending flag of every channel. It can be read at offset 0x00 of any window and is also driven on its own output port. A write of any value to a channel's restart register copies the start value into the live counter at once.

Top module: `chan_timer`

## Requirements
- R1: After reset every register reads 0, all channels are disabled and unmasked, every interrupt line is low and the status word is 0.
- R2: Channel n's window begins at byte address n*0x40. Offsets: 0x04 mode (bit 0), 0x08 start value (32 bits), 0x10 enable (bit 0), 0x14 restart, 0x18 live count (read-only), 0x20 clear, 0x24 mask (bit 0). Single-bit registers read back bit 0 with all other bits 0.
- R3: While enabled and not parked, the live count falls by exactly one per clock. While disabled, it holds.
- R4: An enabled counter at 0 sets its pending flag on the next clock edge. In repeating mode (mode bit 0) it takes the start value on that same edge, so the period is start value + 1 clocks.
- R5: In one-pass mode (mode bit 1), expiry leaves the counter parked at 0. It counts and signals nothing more until a restart write or an enable write with bit 0 set.
- R6: A write of any data to offset 0x14 makes the live count equal the start value on the following cycle, whether the channel is enabled or not.
- R7: A write to offset 0x20 with bit 0 set clears the pending flag. With bit 0 clear it has no effect. If an expiry falls on the same edge as the clear, the flag stays set.
- R8: Bit 1 of offset 0x20 reads 1 for exactly the two cycles that follow a clearing write and reads 0 after that. Bit 0 reads 0.
- R9: The pending flag is set regardless of the mask. The interrupt line equals pending AND NOT mask.
- R10: The status word (bit n = channel n's pending flag) reads at offset 0x00 of every window and matches the status port. Writes to it change nothing.
- R11: Reads of unlisted or unaligned offsets return 0, and writes to them change no register.
- R12: A write to one channel's window changes no other channel's registers, count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address; the upper bits select the channel |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | NUM_CH (4) | Per-channel interrupt, pending and not masked |
| irq_status | output | NUM_CH (4) | Per-channel pending flags |

## Verification
The bench builds the block with its defaults: four channels of 32-bit counters and an 8-bit address. At that size the decode reaches every window and the top channel's select bits are fully used. Small start values (0, 2 and 5) keep expiry, the repeating period and the parking in one-pass mode within a few cycles. A start value of 0 in repeating mode makes a channel expire on every clock, so a clear can be made to land on the same edge as an expiry. The full 32-bit start value is checked by register readback rather than by counting it down.

// File: rtl/chan_timer_pkg.sv
package chan_timer_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned WIN_W  = 6;

    localparam logic [WIN_W-1:0] OFS_STATUS  = 6'h00;
    localparam logic [WIN_W-1:0] OFS_MODE    = 6'h04;
    localparam logic [WIN_W-1:0] OFS_START   = 6'h08;
    localparam logic [WIN_W-1:0] OFS_ENABLE  = 6'h10;
    localparam logic [WIN_W-1:0] OFS_RESTART = 6'h14;
    localparam logic [WIN_W-1:0] OFS_COUNT   = 6'h18;
    localparam logic [WIN_W-1:0] OFS_CLEAR   = 6'h20;
    localparam logic [WIN_W-1:0] OFS_MASK    = 6'h24;

    typedef struct packed {
        logic mode;
        logic start;
        logic enable;
        logic restart;
        logic clear;
        logic mask;
    } chan_wr_t;

endpackage

// File: rtl/chan_timer_decode.sv
module chan_timer_decode
    import chan_timer_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = WIN_W + CH_W
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       we,
    output logic [CH_W-1:0]            sel_ch,
    output logic [WIN_W-1:0]           sel_ofs,
    output chan_wr_t [NUM_CH-1:0]      wr
);

    assign sel_ofs = addr[WIN_W-1:0];
    assign sel_ch  = addr[ADDR_W-1:WIN_W];

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr[c] = '0;
            if (we && (sel_ch == CH_W'(c))) begin
                case (sel_ofs)
                    OFS_MODE:    wr[c].mode    = 1'b1;
                    OFS_START:   wr[c].start   = 1'b1;
                    OFS_ENABLE:  wr[c].enable  = 1'b1;
                    OFS_RESTART: wr[c].restart = 1'b1;
                    OFS_CLEAR:   wr[c].clear   = 1'b1;
                    OFS_MASK:    wr[c].mask    = 1'b1;
                    default:     wr[c]         = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/chan_timer_channel.sv
module chan_timer_channel
    import chan_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [WIN_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              pend_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  start_o,
    output logic              enable_o,
    output logic              busy_o
);

    typedef struct packed {
        logic             mode;
        logic             enable;
        logic             mask;
        logic             pend;
        logic             parked;
        logic [1:0]       busy;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        expire;

    always_comb begin
        st_d   = st_q;
        expire = st_q.enable && !st_q.parked && (st_q.cnt == '0);

        if (st_q.busy != 2'd0) st_d.busy = st_q.busy - 2'd1;
        if (wr.mode)  st_d.mode  = wdata[0];
        if (wr.start) st_d.start = wdata[CNT_W-1:0];
        if (wr.mask)  st_d.mask  = wdata[0];
        if (wr.enable) begin
            st_d.enable = wdata[0];
            if (wdata[0]) st_d.parked = 1'b0;
        end
        if (wr.clear && wdata[0]) begin
            st_d.pend = 1'b0;
            st_d.busy = 2'd2;
        end

        if (expire) begin
            st_d.pend   = 1'b1;
            st_d.cnt    = st_q.mode ? '0 : st_q.start;
            st_d.parked = st_q.mode;
        end else if (st_q.enable && !st_q.parked) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        if (wr.restart) begin
            st_d.cnt    = st_q.start;
            st_d.parked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_ofs)
            OFS_MODE:   rd_data = DATA_W'(st_q.mode);
            OFS_START:  rd_data = DATA_W'(st_q.start);
            OFS_ENABLE: rd_data = DATA_W'(st_q.enable);
            OFS_COUNT:  rd_data = DATA_W'(st_q.cnt);
            OFS_CLEAR:  rd_data = DATA_W'({(st_q.busy != 2'd0), 1'b0});
            OFS_MASK:   rd_data = DATA_W'(st_q.mask);
            default:    rd_data = '0;
        endcase
    end

    assign pend_o   = st_q.pend;
    assign irq_o    = st_q.pend & ~st_q.mask;
    assign count_o  = st_q.cnt;
    assign start_o  = st_q.start;
    assign enable_o = st_q.enable;
    assign busy_o   = (st_q.busy != 2'd0);

endmodule

// File: rtl/chan_timer.sv
module chan_timer
    import chan_timer_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = WIN_W + CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] irq_status
);

    logic [CH_W-1:0]                sel_ch;
    logic [WIN_W-1:0]               sel_ofs;
    chan_wr_t [NUM_CH-1:0]          ch_wr;
    logic [NUM_CH-1:0][DATA_W-1:0]  ch_rd;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_start;
    logic [NUM_CH-1:0]              ch_enable;
    logic [NUM_CH-1:0]              ch_busy;
    logic [NUM_CH-1:0]              ch_restart_wr;
    logic [NUM_CH-1:0]              ch_clear_wr;

    chan_timer_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr    (bus_addr),
        .we      (bus_we),
        .sel_ch  (sel_ch),
        .sel_ofs (sel_ofs),
        .wr      (ch_wr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_timer_channel #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (ch_wr[g]),
            .wdata    (bus_wdata),
            .rd_ofs   (sel_ofs),
            .rd_data  (ch_rd[g]),
            .pend_o   (irq_status[g]),
            .irq_o    (irq[g]),
            .count_o  (ch_count[g]),
            .start_o  (ch_start[g]),
            .enable_o (ch_enable[g]),
            .busy_o   (ch_busy[g])
        );
        assign ch_restart_wr[g] = ch_wr[g].restart;
        assign ch_clear_wr[g]   = ch_wr[g].clear & bus_wdata[0];
    end

    assign bus_rdata = (sel_ofs == OFS_STATUS) ? DATA_W'(irq_status) : ch_rd[sel_ch];

endmodule

// File: rtl/chan_timer_chk.sv
module chan_timer_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH-1:0]         irq,
    input logic [NUM_CH-1:0]         irq_status,
    input logic [NUM_CH-1:0]         restart_wr,
    input logic [NUM_CH-1:0]         clear_wr,
    input logic [NUM_CH-1:0][CNT_W-1:0] count,
    input logic [NUM_CH-1:0][CNT_W-1:0] start,
    input logic [NUM_CH-1:0]         enable,
    input logic [NUM_CH-1:0]         busy
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> irq_status[i]); // R9

        AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            restart_wr[i] |=> count[i] == $past(start[i])); // R6

        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (enable[i] && !restart_wr[i] && count[i] != '0)
            |=> count[i] == $past(count[i]) - CNT_W'(1)); // R3

        AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_status[i] && !clear_wr[i]) |=> irq_status[i]); // R7

        AST_PEND_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_status[i]) |-> $past(count[i]) == '0); // R4

        AST_BUSY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            clear_wr[i] |=> busy[i]); // R8

        AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[i]) |-> $past(clear_wr[i])); // R8
    end

endmodule

bind chan_timer chan_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .irq_status (irq_status),
    .restart_wr (ch_restart_wr),
    .clear_wr   (ch_clear_wr),
    .count      (ch_count),
    .start      (ch_start),
    .enable     (ch_enable),
    .busy       (ch_busy)
);

// File: tb/tb_chan_timer.sv
module tb_chan_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic [3:0]  irq_status;

    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    chan_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_status(irq_status)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h04, 32'h1,        32'h0,        4'd2},  // R2 mode ch0
        '{1'b0, 8'h04, 32'h0,        32'h1,        4'd2},
        '{1'b1, 8'h48, 32'hDEADBEEF, 32'h0,        4'd2},  // R2 start ch1
        '{1'b0, 8'h48, 32'h0,        32'hDEADBEEF, 4'd2},
        '{1'b1, 8'hA4, 32'hFFFFFFFF, 32'h0,        4'd2},  // R2 mask ch2, bit 0 only
        '{1'b0, 8'hA4, 32'h0,        32'h1,        4'd2},
        '{1'b1, 8'hC4, 32'hFFFFFFFE, 32'h0,        4'd2},  // R2 mode ch3 bit0 = 0
        '{1'b0, 8'hC4, 32'h0,        32'h0,        4'd2},
        '{1'b0, 8'h3C, 32'h0,        32'h0,        4'd11}, // R11 reserved read
        '{1'b1, 8'h0C, 32'h12345678, 32'h0,        4'd11}, // R11 reserved write
        '{1'b0, 8'h0C, 32'h0,        32'h0,        4'd11},
        '{1'b1, 8'h09, 32'h55555555, 32'h0,        4'd11}, // R11 unaligned write
        '{1'b0, 8'h08, 32'h0,        32'h0,        4'd11},
        '{1'b0, 8'h58, 32'h0,        32'h0,        4'd6},  // count before restart
        '{1'b1, 8'h54, 32'h0,        32'h0,        4'd6},  // R6 restart with data 0
        '{1'b0, 8'h58, 32'h0,        32'hDEADBEEF, 4'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // caller stands just after a falling edge; one rising edge takes the write
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 status", 32'(irq_status), 32'h0);
        rd(8'hC8, v); check("R1 start ch3", v, 32'h0);
        rd(8'h90, v); check("R1 enable ch2", v, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].is_wr) begin
                wr(VECS[k].addr, VECS[k].data);
            end else begin
                rd(VECS[k].addr, v);
                check($sformatf("R%0d table %0d", VECS[k].req, k), v, VECS[k].exp);
            end
        end
        rd(8'h08, v); check("R12 ch0 start untouched", v, 32'h0);

        do_reset();
        // R3 / R4 repeating mode on ch0, start value 5
        wr(8'h08, 32'd5);
        wr(8'h14, 32'h0);
        wr(8'h10, 32'h1);
        rd(8'h18, v); check("R3 count after enable", v, 32'd5);
        tick(1); rd(8'h18, v); check("R3 count step", v, 32'd4);
        tick(4); rd(8'h18, v); check("R3 count at zero", v, 32'd0);
        check("R4 no flag before expiry", 32'(irq_status), 32'h0);
        tick(1); rd(8'h18, v); check("R4 reloaded", v, 32'd5);
        check("R4 flag set", 32'(irq_status), 32'h1);
        check("R9 irq unmasked", 32'(irq), 32'h1);
        // R9 mask
        wr(8'h24, 32'h1);
        check("R9 irq masked", 32'(irq), 32'h0);
        check("R9 flag kept under mask", 32'(irq_status), 32'h1);
        wr(8'h24, 32'h0);
        check("R9 irq unmasked again", 32'(irq), 32'h1);
        // R3 hold when disabled
        wr(8'h10, 32'h0);
        rd(8'h18, v);
        tick(3);
        begin
            logic [31:0] v2;
            rd(8'h18, v2); check("R3 hold when disabled", v2, v);
        end
        // R7 / R8 clear
        wr(8'h20, 32'h2);
        check("R7 clear with bit0=0 ignored", 32'(irq_status), 32'h1);
        wr(8'h20, 32'h1);
        check("R7 flag cleared", 32'(irq_status), 32'h0);
        rd(8'h20, v); check("R8 busy cycle 1", v, 32'h2);
        tick(1); rd(8'h20, v); check("R8 busy cycle 2", v, 32'h2);
        tick(1); rd(8'h20, v); check("R8 busy done", v, 32'h0);

        // R5 one-pass on ch2, start value 2
        wr(8'h88, 32'd2);
        wr(8'h94, 32'h1);
        wr(8'h84, 32'h1);
        wr(8'h90, 32'h1);
        tick(3);
        check("R5 expiry flag", 32'(irq_status), 32'h4);
        wr(8'hA0, 32'h1);
        tick(4);
        check("R5 no flag while parked", 32'(irq_status), 32'h0);
        rd(8'h98, v); check("R5 parked at zero", v, 32'h0);
        wr(8'h94, 32'hFFFF);
        rd(8'h98, v); check("R6 restart any value", v, 32'd2);
        tick(3);
        check("R5 runs again after restart", 32'(irq_status), 32'h4);

        // R7 clear collides with expiry on ch3 (start 0, repeating)
        wr(8'hD0, 32'h1);
        tick(1);
        check("R4 start 0 expires", 32'(irq_status), 32'hC);
        wr(8'hE0, 32'h1);
        check("R7 expiry beats clear", 32'(irq_status), 32'hC);
        wr(8'hD0, 32'h0);
        wr(8'hE0, 32'h1);
        check("R7 clear after disable", 32'(irq_status), 32'h4);

        // R10 status word
        rd(8'h40, v); check("R10 status in ch1 window", v, 32'(irq_status));
        wr(8'h00, 32'h0);
        wr(8'hC0, 32'hF);
        rd(8'h00, v); check("R10 status write ignored", v, 32'h4);
        // R12 ch1 untouched by others
        rd(8'h58, v); check("R12 ch1 count", v, 32'h0);
        check("R12 ch1 irq", 32'(irq[1]), 32'h0);

        finish_run();
    end

endmodule